// File: doc/BRIEF.md
# Rename-Stage Move Elimination Gate

This block sits beside the register renamer. For each register-to-register copy that reaches rename, it decides in the same cycle whether the copy can be removed. A removed copy allocates no physical register. Instead, its destination is recorded as an alias of the register that actually holds the value. The block also sees ordinary register writes and zeroing idioms, so it can keep two pieces of per-register state up to date: a known-zero bit and an alias field.

Every logical register belongs to one of several register files. Each file has its own elimination budget for a rename group, and a file may be limited to removing only copies of known-zero values. Budgets and the zero-only setting are build-time parameters.

The decision, the zero-copy flag and the alias root are combinational. A write or an elimination changes the state only on a clock edge where `req_commit` accompanies `req_valid`. A `group_start` beat opens a new rename group: all per-file budgets are refilled, and the request presented in that same beat already sees a full budget.

Top module: `mvelim_gate`

## Requirements
- R1: A copy is eliminated only when `src_file` equals `dst_file` and that index names an existing file (below `NUM_FILES`); otherwise `elim` is 0.
- R2: When `dst_wide` is 1, elimination also needs both `wide_allow` and `clears_upper` to be 1.
- R3: Each file has its own cap on eliminations per rename group (defaults: file 0 allows 2, file 1 is unlimited because its cap is 0, file 2 allows 1). Once the cap is reached, further copies in that file are refused. Files do not share budgets.
- R4: `group_start` resets every file's elimination count. A request in the same beat is judged against an empty count. This applies even when that beat carries no request.
- R5: In a zero-only file (default: file 2 only), a copy is eliminated only if its source's known-zero bit is set.
- R6: `alias_root` is the source's alias when the source has one, otherwise the source itself. A committed elimination stores `alias_root` as the destination's alias, so chains never exceed one level.
- R7: `zero_move` is 1 exactly when `elim` is 1 and the source is known zero.
- R8: A committed write that is not an elimination clears the destination's alias. This covers a refused copy, a plain write and a zeroing idiom.
- R9: A committed zeroing idiom sets the destination's known-zero bit. A committed plain write or refused copy clears it. A committed elimination copies the source's bit into the destination's bit.
- R10: After reset, no register has an alias and no register is known zero. Register 0 is never eliminated, as source or as destination. With `req_valid` low, `elim` is 0.
- R11: A request without `req_commit` leaves the alias fields and known-zero bits unchanged. The request kind is encoded in `req_kind` as: 0 = copy, 1 = zeroing idiom, 2 = plain write, 3 = none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| group_start | input | 1 | First beat of a rename group; refills all budgets |
| req_valid | input | 1 | A request is presented |
| req_commit | input | 1 | Apply the request's state update at this edge |
| req_kind | input | 2 | 0 copy, 1 zeroing idiom, 2 plain write, 3 none |
| src_reg | input | $clog2(NUM_REGS) | Source logical register of a copy |
| dst_reg | input | $clog2(NUM_REGS) | Destination logical register |
| src_file | input | FW | Register file owning the source |
| dst_file | input | FW | Register file owning the destination |
| dst_wide | input | 1 | Destination is renamed through a wider register |
| wide_allow | input | 1 | The wider register's class permits elimination |
| clears_upper | input | 1 | The write clears the upper part of the wider register |
| elim | output | 1 | Copy is eliminated |
| zero_move | output | 1 | Eliminated copy moves a known-zero value |
| alias_root | output | $clog2(NUM_REGS) | Register the destination would alias |

## Verification
Two things can coincide in one beat: a budget refill on `group_start` and a copy that consumes the budget. The bench drives a file to its cap with `group_start` low and confirms a further copy is refused. It then presents a copy together with `group_start` and expects it to be accepted, since it sees an empty count. A refill beat with no request, followed by a copy, is also checked. A second coincidence arises when the source and destination of a committed copy share state through an alias. Here the bench verifies that chains collapse to the root and that the known-zero bit travels with the copy.

// File: rtl/mvelim_pkg.sv
package mvelim_pkg;
  typedef enum logic [1:0] {
    KIND_COPY  = 2'd0,
    KIND_ZERO  = 2'd1,
    KIND_PLAIN = 2'd2,
    KIND_NONE  = 2'd3
  } req_kind_e;
endpackage

// File: rtl/mvelim_budget.sv
module mvelim_budget #(
  parameter int NUM_FILES = 3,
  parameter int FW        = 2,
  parameter int CAP_W     = 4,
  parameter logic [NUM_FILES*CAP_W-1:0] FILE_CAP = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          group_start,
  input  logic          commit_v,
  input  logic          elim,
  input  logic [FW-1:0] dst_file,
  output logic          at_cap
);
  localparam int FSPAN = 1 << FW;

  logic [FSPAN-1:0] cap_hit;

  for (genvar f = 0; f < FSPAN; f++) begin : g_file
    if (f < NUM_FILES) begin : g_real
      localparam logic [CAP_W-1:0] CAP_F = FILE_CAP[f*CAP_W +: CAP_W];
      logic [CAP_W-1:0] cnt_q;
      logic [CAP_W-1:0] base;
      logic             bump;

      assign base = group_start ? '0 : cnt_q;
      assign bump = commit_v && elim && (dst_file == f[FW-1:0]);
      assign cap_hit[f] = (CAP_F != '0) && (base >= CAP_F);

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (bump && (base != '1)) begin
          cnt_q <= base + {{(CAP_W-1){1'b0}}, 1'b1};
        end else begin
          cnt_q <= base;
        end
      end

      if (CAP_F != '0) begin : g_capped
        assert_cap_bound_R3: assert property (@(posedge clk) disable iff (rst)
          cnt_q <= CAP_F);
      end

      assert_group_refill_R4: assert property (@(posedge clk) disable iff (rst)
        group_start |=> (cnt_q <= {{(CAP_W-1){1'b0}}, 1'b1}));
    end else begin : g_none
      assign cap_hit[f] = 1'b1;
    end
  end

  assign at_cap = cap_hit[dst_file];
endmodule

// File: rtl/mvelim_decide.sv
module mvelim_decide
  import mvelim_pkg::*;
#(
  parameter int NUM_FILES = 3,
  parameter int FW        = 2,
  parameter int IDW       = 4,
  parameter logic [NUM_FILES-1:0] FILE_ZERO_ONLY = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [1:0]     req_kind,
  input  logic [IDW-1:0] src_reg,
  input  logic [IDW-1:0] dst_reg,
  input  logic [FW-1:0]  src_file,
  input  logic [FW-1:0]  dst_file,
  input  logic           dst_wide,
  input  logic           wide_allow,
  input  logic           clears_upper,
  input  logic           at_cap,
  input  logic           src_zero,
  input  logic [IDW-1:0] src_alias,
  output logic           elim,
  output logic           zero_move,
  output logic [IDW-1:0] alias_root
);
  localparam int FSPAN = 1 << FW;

  logic [FSPAN-1:0] file_exists;
  logic [FSPAN-1:0] zero_only_tab;

  for (genvar f = 0; f < FSPAN; f++) begin : g_tab
    if (f < NUM_FILES) begin : g_real
      assign file_exists[f]   = 1'b1;
      assign zero_only_tab[f] = FILE_ZERO_ONLY[f];
    end else begin : g_none
      assign file_exists[f]   = 1'b0;
      assign zero_only_tab[f] = 1'b0;
    end
  end

  logic is_copy, file_ok, ids_ok, wide_ok, zero_ok, zero_only;

  always_comb begin
    is_copy   = req_valid && (req_kind_e'(req_kind) == KIND_COPY);
    file_ok   = (src_file == dst_file) && file_exists[dst_file];
    ids_ok    = (src_reg != '0) && (dst_reg != '0);
    wide_ok   = !dst_wide || (wide_allow && clears_upper);
    zero_only = zero_only_tab[dst_file];
    zero_ok   = !zero_only || src_zero;
    elim      = is_copy && file_ok && ids_ok && wide_ok && zero_ok && !at_cap;
    zero_move = elim && src_zero;
    alias_root = (src_alias != '0) ? src_alias : src_reg;
  end

  assert_same_file_R1: assert property (@(posedge clk) disable iff (rst)
    elim |-> (src_file == dst_file));
  assert_wide_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (elim && dst_wide) |-> (wide_allow && clears_upper));
  assert_zero_only_R5: assert property (@(posedge clk) disable iff (rst)
    (elim && zero_only) |-> src_zero);
  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (rst)
    zero_move |-> elim);
  assert_no_reg0_R10: assert property (@(posedge clk) disable iff (rst)
    elim |-> (src_reg != '0 && dst_reg != '0));
endmodule

// File: rtl/mvelim_regstate.sv
module mvelim_regstate
  import mvelim_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int IDW      = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           commit_v,
  input  logic [1:0]     req_kind,
  input  logic [IDW-1:0] src_reg,
  input  logic [IDW-1:0] dst_reg,
  input  logic           elim,
  input  logic           zero_move,
  input  logic [IDW-1:0] alias_root,
  output logic           src_zero,
  output logic [IDW-1:0] src_alias
);
  logic [IDW-1:0]      alias_q [NUM_REGS];
  logic [NUM_REGS-1:0] zero_q;

  logic           wr_en;
  logic [IDW-1:0] wr_alias;
  logic           wr_zero;

  always_comb begin
    wr_en    = commit_v && (dst_reg != '0) && (req_kind_e'(req_kind) != KIND_NONE);
    wr_alias = '0;
    wr_zero  = 1'b0;
    if (elim) begin
      wr_alias = alias_root;
      wr_zero  = zero_move;
    end else if (req_kind_e'(req_kind) == KIND_ZERO) begin
      wr_zero  = 1'b1;
    end
  end

  assign src_zero  = zero_q[src_reg];
  assign src_alias = alias_q[src_reg];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) alias_q[r] <= '0;
      zero_q <= '0;
    end else if (wr_en) begin
      alias_q[dst_reg] <= wr_alias;
      zero_q[dst_reg]  <= wr_zero;
    end
  end

  assert_alias_root_R6: assert property (@(posedge clk) disable iff (rst)
    (commit_v && elim) |=> (alias_q[$past(dst_reg)] == $past(alias_root)));
  assert_plain_unalias_R8: assert property (@(posedge clk) disable iff (rst)
    (commit_v && !elim && dst_reg != '0 && req_kind_e'(req_kind) != KIND_NONE)
      |=> (alias_q[$past(dst_reg)] == '0));
  assert_zero_set_R9: assert property (@(posedge clk) disable iff (rst)
    (commit_v && dst_reg != '0 && req_kind_e'(req_kind) == KIND_ZERO)
      |=> zero_q[$past(dst_reg)]);
  assert_hold_state_R11: assert property (@(posedge clk) disable iff (rst)
    !commit_v |=> $stable(zero_q));
endmodule

// File: rtl/mvelim_gate.sv
module mvelim_gate
  import mvelim_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int NUM_FILES = 3,
  parameter int CAP_W     = 4,
  parameter logic [NUM_FILES*CAP_W-1:0] FILE_CAP = {4'd1, 4'd0, 4'd2},
  parameter logic [NUM_FILES-1:0] FILE_ZERO_ONLY = 3'b100,
  localparam int IDW = $clog2(NUM_REGS),
  localparam int FW  = (NUM_FILES > 1) ? $clog2(NUM_FILES) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           group_start,
  input  logic           req_valid,
  input  logic           req_commit,
  input  logic [1:0]     req_kind,
  input  logic [IDW-1:0] src_reg,
  input  logic [IDW-1:0] dst_reg,
  input  logic [FW-1:0]  src_file,
  input  logic [FW-1:0]  dst_file,
  input  logic           dst_wide,
  input  logic           wide_allow,
  input  logic           clears_upper,
  output logic           elim,
  output logic           zero_move,
  output logic [IDW-1:0] alias_root
);
  logic           commit_v;
  logic           at_cap;
  logic           src_zero;
  logic [IDW-1:0] src_alias;

  assign commit_v = req_valid && req_commit;

  mvelim_budget #(
    .NUM_FILES(NUM_FILES), .FW(FW), .CAP_W(CAP_W), .FILE_CAP(FILE_CAP)
  ) u_budget (
    .clk(clk), .rst(rst), .group_start(group_start), .commit_v(commit_v),
    .elim(elim), .dst_file(dst_file), .at_cap(at_cap)
  );

  mvelim_decide #(
    .NUM_FILES(NUM_FILES), .FW(FW), .IDW(IDW), .FILE_ZERO_ONLY(FILE_ZERO_ONLY)
  ) u_decide (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .src_reg(src_reg), .dst_reg(dst_reg), .src_file(src_file),
    .dst_file(dst_file), .dst_wide(dst_wide), .wide_allow(wide_allow),
    .clears_upper(clears_upper), .at_cap(at_cap), .src_zero(src_zero),
    .src_alias(src_alias), .elim(elim), .zero_move(zero_move),
    .alias_root(alias_root)
  );

  mvelim_regstate #(
    .NUM_REGS(NUM_REGS), .IDW(IDW)
  ) u_regstate (
    .clk(clk), .rst(rst), .commit_v(commit_v), .req_kind(req_kind),
    .src_reg(src_reg), .dst_reg(dst_reg), .elim(elim),
    .zero_move(zero_move), .alias_root(alias_root), .src_zero(src_zero),
    .src_alias(src_alias)
  );
endmodule

// File: tb/mvelim_gate_bench.sv
module mvelim_gate_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       group_start = 1'b0, req_valid = 1'b0, req_commit = 1'b0;
  logic [1:0] req_kind = 2'd3;
  logic [3:0] src_reg = '0, dst_reg = '0;
  logic [1:0] src_file = '0, dst_file = '0;
  logic       dst_wide = 1'b0, wide_allow = 1'b0, clears_upper = 1'b0;
  logic       elim, zero_move;
  logic [3:0] alias_root;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mvelim_gate u_mvelim_gate (
    .clk(clk), .rst(rst), .group_start(group_start), .req_valid(req_valid),
    .req_commit(req_commit), .req_kind(req_kind), .src_reg(src_reg),
    .dst_reg(dst_reg), .src_file(src_file), .dst_file(dst_file),
    .dst_wide(dst_wide), .wide_allow(wide_allow), .clears_upper(clears_upper),
    .elim(elim), .zero_move(zero_move), .alias_root(alias_root)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic req(input int kind, input int s, input int d, input int sf,
                     input int df, input bit wide, input bit allow,
                     input bit clr, input bit gs, input bit cm, input bit vld);
    @(negedge clk);
    req_kind = kind[1:0]; src_reg = s[3:0]; dst_reg = d[3:0];
    src_file = sf[1:0]; dst_file = df[1:0]; dst_wide = wide;
    wide_allow = allow; clears_upper = clr; group_start = gs;
    req_commit = cm; req_valid = vld;
    #5;
  endtask

  task automatic mv(input int s, input int d, input int f, input bit gs, input bit cm);
    req(0, s, d, f, f, 0, 0, 0, gs, cm, 1);
  endtask

  task automatic wr(input int kind, input int d, input bit cm);
    req(kind, 0, d, 1, 1, 0, 0, 0, 1, cm, 1);
  endtask

  task automatic t_reset;
    mv(1, 2, 1, 1, 0);
    chk("R10 reset elim", elim, 1);
    chk("R10 reset not zero", zero_move, 0);
    chk("R10 reset no alias", alias_root, 1);
    req(0, 1, 2, 1, 1, 0, 0, 0, 1, 0, 0);
    chk("R10 no valid", elim, 0);
  endtask

  task automatic t_reg0;
    mv(0, 3, 1, 1, 0); chk("R10 src reg0", elim, 0);
    mv(3, 0, 1, 1, 0); chk("R10 dst reg0", elim, 0);
  endtask

  task automatic t_files;
    req(0, 1, 2, 0, 1, 0, 0, 0, 1, 0, 1); chk("R1 cross file", elim, 0);
    req(0, 1, 2, 3, 3, 0, 0, 0, 1, 0, 1); chk("R1 missing file", elim, 0);
  endtask

  task automatic t_wide;
    req(0, 1, 2, 1, 1, 1, 1, 1, 1, 0, 1); chk("R2 wide ok", elim, 1);
    req(0, 1, 2, 1, 1, 1, 0, 1, 1, 0, 1); chk("R2 wide no allow", elim, 0);
    req(0, 1, 2, 1, 1, 1, 1, 0, 1, 0, 1); chk("R2 wide no clear", elim, 0);
  endtask

  task automatic t_chain;
    mv(1, 2, 1, 1, 1); chk("R6 first link", alias_root, 1);
    mv(2, 3, 1, 1, 1); chk("R6 collapse", alias_root, 1);
    mv(3, 4, 1, 1, 0); chk("R6 stored root", alias_root, 1);
  endtask

  task automatic t_unalias;
    wr(2, 2, 1);
    mv(2, 5, 1, 1, 0); chk("R8 plain clears alias", alias_root, 2);
    req(0, 1, 3, 0, 1, 0, 0, 0, 1, 1, 1); chk("R1 refused copy", elim, 0);
    mv(3, 6, 1, 1, 0); chk("R8 refused copy clears alias", alias_root, 3);
    wr(1, 4, 1);
    mv(4, 6, 1, 1, 0); chk("R8 zero idiom clears alias", alias_root, 4);
  endtask

  task automatic t_zero;
    wr(1, 7, 1);
    mv(7, 8, 1, 1, 1);
    chk("R7 zero copy elim", elim, 1); chk("R7 zero copy flag", zero_move, 1);
    mv(8, 9, 1, 1, 0);
    chk("R9 zero bit copied", zero_move, 1); chk("R6 root via zero", alias_root, 7);
    wr(2, 7, 1);
    mv(7, 9, 1, 1, 0); chk("R9 plain clears zero", zero_move, 0);
    mv(1, 8, 1, 1, 1);
    mv(8, 9, 1, 1, 0); chk("R9 nonzero copy clears", zero_move, 0);
  endtask

  task automatic t_zero_only;
    mv(1, 10, 2, 1, 0); chk("R5 nonzero refused", elim, 0);
    wr(1, 11, 1);
    mv(11, 10, 2, 1, 0);
    chk("R5 zero accepted", elim, 1); chk("R7 zero-only flag", zero_move, 1);
  endtask

  task automatic t_cap;
    mv(1, 12, 0, 1, 1); chk("R3 cap first", elim, 1);
    mv(1, 13, 0, 0, 1); chk("R3 cap second", elim, 1);
    mv(1, 14, 0, 0, 1); chk("R3 cap reached", elim, 0);
    mv(1, 14, 1, 0, 0); chk("R3 other file free", elim, 1);
    for (int i = 0; i < 20; i++) begin
      mv(1, 5 + (i % 4), 1, 0, 1);
      chk("R3 unlimited file", elim, 1);
    end
  endtask

  task automatic t_refill;
    mv(1, 14, 0, 1, 1); chk("R4 same-beat refill", elim, 1);
    mv(1, 13, 0, 0, 1); chk("R4 count continues", elim, 1);
    mv(1, 12, 0, 0, 0); chk("R4 full again", elim, 0);
    req(3, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    mv(1, 12, 0, 0, 0); chk("R4 idle refill", elim, 1);
  endtask

  task automatic t_nocommit;
    mv(7, 15, 1, 1, 0); chk("R11 uncommitted elim", elim, 1);
    mv(15, 14, 1, 1, 0); chk("R11 alias untouched", alias_root, 15);
    wr(1, 15, 0);
    mv(15, 14, 1, 1, 0); chk("R11 zero untouched", zero_move, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset(); t_reg0(); t_files(); t_wide(); t_chain(); t_unalias();
    t_zero(); t_zero_only(); t_cap(); t_refill(); t_nocommit();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule